// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table kept in main memory. A requester presents a virtual address, an access kind (load, store or instruction fetch) and a privilege flag (user or kernel), together with the physical base of the top-level table. The walker then reads one word from the top-level table and, if that entry allows it, one word from the second-level table the entry points to.

Each walk ends with a one-cycle completion pulse that carries one of three results: a physical address, a page fault (an entry on the path is not valid) or a protection fault (an entry on the path does not permit the access). Only one walk is in flight at a time. The memory side is a simple word-read port: a one-cycle read strobe with an address, and some cycles later a one-cycle response strobe with the data word. The walker does not cache translations and does not handle faults itself; it only reports them.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `mem_req_valid` and `done_valid` are 0.
- R2: A request is taken only while `req_ready` is 1. While a walk is in progress, `req_valid` and the other request inputs are ignored; the outcome follows the taken request and no extra walk or read follows it. Each memory read is a single-cycle strobe.
- R3: The first read goes to `root_base + 4*VA[31:22]`.
- R4: The second read goes to `(first-entry PPN << 12) + 4*VA[21:12]`.
- R5: A first-level entry with bit 31 (valid) equal to 0 ends the walk with a page fault after exactly one read.
- R6: A second-level entry with bit 31 equal to 0 ends the walk with a page fault after two reads.
- R7: Entry bits 30:29 hold the rights: 00 read-only (loads), 01 read/write (loads, stores), 10 executable (fetches, loads), 11 kernel read/write (loads and stores in kernel mode only). Access codes are 00 load, 01 store, 10 fetch; code 11 is never permitted. `req_user` = 1 means user mode. A valid entry whose rights deny the access raises a protection fault.
- R8: The rights of the first-level entry are checked too; a denied first-level entry ends the walk with a protection fault after one read and no second read. At each level the valid bit is checked before the rights.
- R9: A walk that passes both levels returns `done_paddr` = {second-entry PPN, VA[11:0]} with both fault flags 0.
- R10: `done_valid` is high for exactly one cycle per walk; at most one fault flag is set with it; on a fault `done_paddr` is 0; `req_ready` is 1 in the cycle after `done_valid`.
- R11: The PPN is entry bits 19:0; bits 28:20 are reserved and have no effect on the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_access | input | 2 | Access kind: 00 load, 01 store, 10 fetch |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| root_base | input | 32 | Physical base of the top-level table |
| mem_req_valid | output | 1 | Memory word read strobe |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Memory read data strobe |
| mem_rsp_data | input | 32 | Entry word returned by memory |
| done_valid | output | 1 | Walk complete, one cycle |
| done_paddr | output | 32 | Translated physical address (0 on a fault) |
| done_pfault | output | 1 | Walk ended in a page fault |
| done_xfault | output | 1 | Walk ended in a protection fault |

## Verification
The bench goes after the walks that stop early: an invalid or denying first-level entry must yield its fault after a single read, and a design that went on to the second level would show a second read to a garbage address or, with inverted check order, a protection fault where a page fault is due. The full grid of rights at both levels against every access kind and both privilege modes is swept, so a swapped rights code or a kernel-only page open to user code shows as a wrong flag. Reserved entry bits are filled with noise, and during busy walks the request inputs are changed, to catch a walker that decodes the wrong PPN bits or takes a second request mid-walk. Random memory latency and random root bases check the two address formulas and the offset carried into the physical address.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  // access kinds presented by the requester
  localparam logic [1:0] ACC_LOAD  = 2'b00;
  localparam logic [1:0] ACC_STORE = 2'b01;
  localparam logic [1:0] ACC_FETCH = 2'b10;

  // rights codes held in each table entry
  localparam logic [1:0] RT_RO  = 2'b00;
  localparam logic [1:0] RT_RW  = 2'b01;
  localparam logic [1:0] RT_EX  = 2'b10;
  localparam logic [1:0] RT_KRW = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE1,
    ST_WAIT1,
    ST_ISSUE2,
    ST_WAIT2,
    ST_DONE
  } walk_st_e;

  // permission matrix shared by both table levels
  function automatic logic rights_allow(logic [1:0] rights, logic [1:0] acc, logic user);
    logic is_ld, is_st, is_fe;
    is_ld = (acc == ACC_LOAD);
    is_st = (acc == ACC_STORE);
    is_fe = (acc == ACC_FETCH);
    case (rights)
      RT_RO:   return is_ld;
      RT_RW:   return is_ld | is_st;
      RT_EX:   return is_ld | is_fe;
      default: return !user && (is_ld | is_st);
    endcase
  endfunction

  // byte offset of entry number idx inside a table of 4-byte entries
  function automatic logic [31:0] entry_offset(logic [31:0] idx);
    return idx << 2;
  endfunction

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10,
  parameter int PPN_W = 20,
  localparam int PA_W = PPN_W + OFF_W
) (
  input  logic             sel_l2,
  input  logic [PA_W-1:0]  root_base,
  input  logic [PPN_W-1:0] l1_ppn,
  input  logic [VA_W-1:0]  vaddr,
  output logic [PA_W-1:0]  addr
);
  import ptw_pkg::*;

  logic [IDX_W-1:0] idx;
  logic [PA_W-1:0]  tbl_base;
  logic [31:0]      idx_wide;
  logic [31:0]      byte_off;

  always_comb begin
    idx      = sel_l2 ? vaddr[OFF_W +: IDX_W] : vaddr[OFF_W+IDX_W +: IDX_W];
    tbl_base = sel_l2 ? {l1_ppn, {OFF_W{1'b0}}} : root_base;
    idx_wide = '0;
    idx_wide[IDX_W-1:0] = idx;
    byte_off = entry_offset(idx_wide);
    addr     = tbl_base + byte_off[PA_W-1:0];
  end

endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check #(
  parameter int PTE_W = 32,
  parameter int PPN_W = 20
) (
  input  logic [PTE_W-1:0] pte,
  input  logic [1:0]       access,
  input  logic             user,
  output logic             pfault,
  output logic             xfault,
  output logic [PPN_W-1:0] ppn
);
  import ptw_pkg::*;

  logic       ent_valid;
  logic [1:0] ent_rights;
  logic       unused_rsvd;

  assign ent_valid   = pte[PTE_W-1];
  assign ent_rights  = pte[PTE_W-2 -: 2];
  assign ppn         = pte[PPN_W-1:0];
  assign unused_rsvd = &{1'b0, pte[PTE_W-4:PPN_W]};

  // valid is examined before rights
  assign pfault = !ent_valid;
  assign xfault = ent_valid && !rights_allow(ent_rights, access, user);

endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10,
  parameter int PPN_W = 20,
  parameter int PTE_W = 32,
  localparam int PA_W = PPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_access,
  input  logic             req_user,
  input  logic [PA_W-1:0]  root_base,
  output logic             mem_req_valid,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             done_valid,
  output logic [PA_W-1:0]  done_paddr,
  output logic             done_pfault,
  output logic             done_xfault
);
  import ptw_pkg::*;

  walk_st_e         state;
  logic [VA_W-1:0]  va_q;
  logic [1:0]       acc_q;
  logic             user_q;
  logic [PA_W-1:0]  base_q;
  logic [PPN_W-1:0] l1ppn_q;
  logic [PA_W-1:0]  res_pa_q;
  logic             res_pf_q;
  logic             res_xf_q;

  // named internal events
  logic             walk_start;
  logic             l1_rsp;
  logic             l2_rsp;
  logic             rsp_fault;
  logic             chk_pf;
  logic             chk_xf;
  logic [PPN_W-1:0] chk_ppn;

  assign req_ready     = (state == ST_IDLE);
  assign walk_start    = req_valid && req_ready;
  assign l1_rsp        = (state == ST_WAIT1) && mem_rsp_valid;
  assign l2_rsp        = (state == ST_WAIT2) && mem_rsp_valid;
  assign rsp_fault     = chk_pf || chk_xf;
  assign mem_req_valid = (state == ST_ISSUE1) || (state == ST_ISSUE2);

  ptw_addr_gen #(
    .VA_W (VA_W),
    .OFF_W(OFF_W),
    .IDX_W(IDX_W),
    .PPN_W(PPN_W)
  ) u_addr (
    .sel_l2   (state == ST_ISSUE2),
    .root_base(base_q),
    .l1_ppn   (l1ppn_q),
    .vaddr    (va_q),
    .addr     (mem_req_addr)
  );

  ptw_pte_check #(
    .PTE_W(PTE_W),
    .PPN_W(PPN_W)
  ) u_check (
    .pte   (mem_rsp_data),
    .access(acc_q),
    .user  (user_q),
    .pfault(chk_pf),
    .xfault(chk_xf),
    .ppn   (chk_ppn)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      va_q     <= '0;
      acc_q    <= '0;
      user_q   <= 1'b0;
      base_q   <= '0;
      l1ppn_q  <= '0;
      res_pa_q <= '0;
      res_pf_q <= 1'b0;
      res_xf_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (walk_start) begin
            va_q     <= req_vaddr;
            acc_q    <= req_access;
            user_q   <= req_user;
            base_q   <= root_base;
            res_pa_q <= '0;
            res_pf_q <= 1'b0;
            res_xf_q <= 1'b0;
            state    <= ST_ISSUE1;
          end
        end
        ST_ISSUE1: state <= ST_WAIT1;
        ST_WAIT1: begin
          if (l1_rsp) begin
            if (rsp_fault) begin
              res_pf_q <= chk_pf;
              res_xf_q <= chk_xf;
              state    <= ST_DONE;
            end else begin
              l1ppn_q <= chk_ppn;
              state   <= ST_ISSUE2;
            end
          end
        end
        ST_ISSUE2: state <= ST_WAIT2;
        ST_WAIT2: begin
          if (l2_rsp) begin
            res_pf_q <= chk_pf;
            res_xf_q <= chk_xf;
            if (!rsp_fault) res_pa_q <= {chk_ppn, va_q[OFF_W-1:0]};
            state <= ST_DONE;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign done_valid  = (state == ST_DONE);
  assign done_paddr  = done_valid ? res_pa_q : '0;
  assign done_pfault = done_valid && res_pf_q;
  assign done_xfault = done_valid && res_xf_q;

  // R2: a read strobe lasts one cycle
  p_single_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

  // R2: the captured request does not move while busy
  p_busy_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(va_q) && $stable(acc_q) && $stable(user_q));

  // R5 and R8: a faulting first-level entry is never followed by a read
  p_l1_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_rsp && rsp_fault) |=> !mem_req_valid && done_valid);

  // R9: the page offset passes through untouched
  p_offset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_pfault && !done_xfault) |-> done_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]);

  // R10: one outcome flag at most
  p_one_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> !(done_pfault && done_xfault));

  // R10: faulting walks return a zero address
  p_fault_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && (done_pfault || done_xfault)) |-> done_paddr == '0);

  // R10: completion is a single pulse and the walker is free right after
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid && req_ready);

endmodule

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_access = '0;
  logic        req_user = 1'b0;
  logic [31:0] root_base = '0;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done_valid;
  logic [31:0] done_paddr;
  logic        done_pfault;
  logic        done_xfault;

  always #2.5 clk = ~clk;

  pt_walker u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_access(req_access), .req_user(req_user),
    .root_base(root_base),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done_valid(done_valid), .done_paddr(done_paddr),
    .done_pfault(done_pfault), .done_xfault(done_xfault)
  );

  // 4 pages of backing memory; anything above reads as zero
  logic [31:0] mem [0:4095];
  int          checks = 0;
  int          fails  = 0;
  int          rd_count = 0;
  logic [31:0] rd_addr [0:7];
  bit          pend = 0;
  int          pend_cnt = 0;
  logic [31:0] pend_addr = '0;
  bit          finished = 0;

  function automatic logic [31:0] rdw(logic [31:0] a);
    if (a[31:14] != 0) return 32'h0;
    return mem[a[13:2]];
  endfunction

  // memory responder: acts on falling edges only
  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (pend) begin
      if (pend_cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = rdw(pend_addr);
        pend = 0;
      end else pend_cnt = pend_cnt - 1;
    end
    if (mem_req_valid) begin
      pend      = 1;
      pend_cnt  = int'($urandom % 4);
      pend_addr = mem_req_addr;
      if (rd_count < 8) rd_addr[rd_count] = mem_req_addr;
      rd_count  = rd_count + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // rights table written as one lookup on {rights, access, user}
  function automatic bit may(logic [1:0] r, logic [1:0] a, logic u);
    case ({r, a})
      4'b00_00: return 1;
      4'b01_00, 4'b01_01: return 1;
      4'b10_00, 4'b10_10: return 1;
      4'b11_00, 4'b11_01: return !u;
      default: return 0;
    endcase
  endfunction

  task automatic walk(input logic [31:0] va, input logic [1:0] acc, input logic usr,
                      input logic [31:0] base, input bit interfere, input string tag);
    logic [31:0] a1, a2, e1, e2, exp_pa;
    bit          exp_pf, exp_xf;
    int          exp_rd, t;
    exp_pf = 0; exp_xf = 0; exp_pa = 0; a2 = 0;
    a1 = base + {20'd0, va[31:22], 2'b00};
    e1 = rdw(a1);
    if (!e1[31]) begin exp_pf = 1; exp_rd = 1; end
    else if (!may(e1[30:29], acc, usr)) begin exp_xf = 1; exp_rd = 1; end
    else begin
      exp_rd = 2;
      a2 = {e1[19:0], 12'd0} + {20'd0, va[21:12], 2'b00};
      e2 = rdw(a2);
      if (!e2[31]) exp_pf = 1;
      else if (!may(e2[30:29], acc, usr)) exp_xf = 1;
      else exp_pa = {e2[19:0], va[11:0]};
    end

    @(negedge clk);
    rd_count = 0;
    req_vaddr = va; req_access = acc; req_user = usr; root_base = base;
    req_valid = 1'b1;
    @(negedge clk);
    if (interfere) begin
      req_vaddr = ~va; req_access = ~acc; req_user = ~usr; root_base = base + 32'h1000;
      @(negedge clk);
    end
    req_valid = 1'b0;
    t = 0;
    while (!done_valid && t < 100) begin @(negedge clk); t++; end
    chk(done_valid, "R10", {tag, " done seen"}, {31'd0, done_valid}, 32'd1);
    chk(done_pfault == exp_pf, exp_rd == 1 ? "R5" : "R6", {tag, " page fault"}, {31'd0, done_pfault}, {31'd0, exp_pf});
    chk(done_xfault == exp_xf, "R7", {tag, " protection fault (R8 R11)"}, {31'd0, done_xfault}, {31'd0, exp_xf});
    chk(done_paddr == exp_pa, "R9", {tag, " paddr (R10 zero on fault)"}, done_paddr, exp_pa);
    chk(rd_count == exp_rd, "R8", {tag, " read count"}, rd_count, exp_rd);
    chk(rd_addr[0] == a1, "R3", {tag, " first address"}, rd_addr[0], a1);
    if (exp_rd == 2) chk(rd_addr[1] == a2, "R4", {tag, " second address"}, rd_addr[1], a2);
    @(negedge clk);
    chk(req_ready && !done_valid, "R10", {tag, " pulse ends, ready"}, {30'd0, req_ready, done_valid}, 32'd2);
    if (interfere) begin
      @(negedge clk); @(negedge clk);
      chk(rd_count == exp_rd && !mem_req_valid, "R2", {tag, " busy request ignored"}, rd_count, exp_rd);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20031104));
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(req_ready && !mem_req_valid && !done_valid, "R1", "in reset",
        {29'd0, req_ready, mem_req_valid, done_valid}, 32'd4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !mem_req_valid && !done_valid, "R1", "after reset",
        {29'd0, req_ready, mem_req_valid, done_valid}, 32'd4);

    // directed table in page 0, reserved bits deliberately noisy (R11)
    mem[0] = 32'h0FF0_0001;                       // invalid, rest set
    mem[1] = 32'h8000_0001 | 32'h1FF0_0000;       // read-only, ppn 1
    mem[2] = 32'hA000_0002;                       // read/write, ppn 2
    mem[1024 * 2 + 5] = 32'h7FFF_FFFF;            // invalid second level
    walk({10'd0, 10'd3, 12'h123}, ACC(0), 0, 32'h0, 0, "R5 l1 invalid");
    walk({10'd1, 10'd3, 12'h456}, ACC(1), 0, 32'h0, 0, "R8 l1 denies store");
    walk({10'd2, 10'd5, 12'h789}, ACC(0), 0, 32'h0, 0, "R6 l2 invalid");

    // full rights grid over both levels (R7 R8 R11)
    for (int r1 = 0; r1 < 4; r1++) begin
      mem[4 + r1] = 32'h8000_0003 | (32'(r1) << 29) | 32'h0AA0_0000;
      for (int r2 = 0; r2 < 4; r2++)
        mem[3 * 1024 + r2] = 32'h8000_0000 | (32'(r2) << 29) | 32'h1550_0000 | (32'hABC00 + 32'(r2));
    end
    for (int r1 = 0; r1 < 4; r1++)
      for (int r2 = 0; r2 < 4; r2++)
        for (int a = 0; a < 4; a++)
          for (int u = 0; u < 2; u++)
            walk({10'(4 + r1), 10'(r2), 12'($urandom)}, 2'(a), 1'(u), 32'h0, 0, "R7 grid");

    // root table at a non-zero base (R3)
    mem[1024 + 9] = 32'hA000_0002;
    mem[2 * 1024 + 7] = 32'h8000_0000 | 32'h000F_00D;
    walk({10'd9, 10'd7, 12'hFED}, ACC(0), 1, 32'h0000_1000, 1, "R3 moved root");

    // random tables, requests and latencies
    for (int i = 0; i < 4096; i++) begin
      logic [31:0] w;
      w = $urandom;
      w[31] = ($urandom % 4) != 0;
      if (($urandom % 8) != 0) w[19:0] = 20'($urandom % 4);
      mem[i] = w;
    end
    for (int n = 0; n < 300; n++)
      walk($urandom, 2'($urandom), 1'($urandom), 32'($urandom % 4) << 12,
           ($urandom % 4) == 0, "R2 random");

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  function automatic logic [1:0] ACC(int k);
    return 2'(k);
  endfunction

endmodule